// File: doc/BRIEF.md
# Whitened Random Key Collector

This block takes a raw random bit stream, one bit per strobe, and runs it through a 128-stage linear feedback shift register that acts as a whitener. Each accepted raw bit is mixed into the register's feedback, and the register's top stage yields one whitened bit per accepted input. Whitened bits are gathered, least significant first, into 128-bit keys. Each finished key is written into an on-chip key memory of 1024 entries, at consecutive addresses starting from zero.

Once the memory holds 1024 keys, collection stops and a completion flag rises. A host reads any stored key by placing an address on the read port; the data appears one cycle later. A start command begins a fresh collection at address zero. It does not reseed the whitener, so keys from a new run continue the register's sequence rather than repeat it.

Top module: `key_whitener_store`

## Requirements
- R1: After reset, `key_count` is 0, `done` is 0, and the whitener holds the nonzero `SEED` value (all-zero is never loaded).
- R2: When a raw bit is accepted, each stage i of the whitener takes the old stage i-1, and stage 0 takes the XOR of old stages 127, 125, 100, 98 and the raw bit.
- R3: A raw bit is accepted only in a cycle with `raw_valid` high, `done` low and `start` low; in any other cycle the whitener and the partial key do not change.
- R4: Each accepted bit produces the whitened bit equal to stage 127 before the shift; the k-th whitened bit of a key (k = 0..127) lands in key bit k.
- R5: The cycle that accepts a key's 128th bit writes that key at address `key_count`; `key_count` then increments by one.
- R6: The write that brings `key_count` to 1024 raises `done`; while `done` is high, raw bits are ignored and `key_count` and memory contents stay unchanged.
- R7: `start` clears `key_count`, `done` and any partial key in the following cycle, leaves the whitener state untouched, and takes priority over a raw bit offered in the same cycle (that bit is dropped).
- R8: `rd_data` shows the key stored at `rd_addr` one clock after `rd_addr` is presented.
- R9: A read of the address being written in the same cycle returns the previous contents of that entry; the new key is visible on the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_bit | input | 1 | Raw random bit |
| raw_valid | input | 1 | Qualifies `raw_bit` this cycle |
| start | input | 1 | Begin a new collection at address 0 |
| rd_addr | input | 10 | Key memory read address |
| done | output | 1 | Memory is full; collection halted |
| key_count | output | 11 | Number of keys stored in this run |
| rd_data | output | 128 | Key read from `rd_addr`, one cycle late |

## Verification
The host read port and the key write path share the memory and can hit the same entry in one cycle. The bench provokes this on the second run: it holds `rd_addr` at 0 while feeding the 128 bits that overwrite entry 0, so the completing cycle reads and writes the same address. The reference model reads before it updates and expects the first-run key on that cycle and the new key on the next one. A start offered together with a valid raw bit is also driven, and the model drops that bit.

// File: rtl/kws_pkg.sv
package kws_pkg;

    // Default geometry of the collector
    localparam int unsigned KWS_LFSR_W = 128;
    localparam int unsigned KWS_KEY_W  = 128;
    localparam int unsigned KWS_DEPTH  = 1024;

    // Feedback stage positions of the whitener polynomial
    localparam int unsigned KWS_TAP_A = 127;
    localparam int unsigned KWS_TAP_B = 125;
    localparam int unsigned KWS_TAP_C = 100;
    localparam int unsigned KWS_TAP_D = 98;

    // Default nonzero load value of the whitener
    localparam logic [KWS_LFSR_W-1:0] KWS_SEED =
        128'hC3A5_96E1_0F7B_2D48_5AF0_1E69_B7C4_8D23;

    // Build a tap mask of the given width from four stage positions
    function automatic logic [KWS_LFSR_W-1:0] kws_tap_mask(
        input int unsigned a, input int unsigned b,
        input int unsigned c, input int unsigned d);
        logic [KWS_LFSR_W-1:0] m;
        m    = '0;
        m[a] = 1'b1;
        m[b] = 1'b1;
        m[c] = 1'b1;
        m[d] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/kws_lfsr.sv
module kws_lfsr
    import kws_pkg::*;
#(
    parameter int unsigned             W    = KWS_LFSR_W,
    parameter logic [KWS_LFSR_W-1:0]   SEED = KWS_SEED,
    parameter int unsigned             TA   = KWS_TAP_A,
    parameter int unsigned             TB   = KWS_TAP_B,
    parameter int unsigned             TC   = KWS_TAP_C,
    parameter int unsigned             TD   = KWS_TAP_D
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         raw_bit,
    output logic [W-1:0] state,
    output logic         white_bit
);

    localparam logic [KWS_LFSR_W-1:0] FULL_MASK = kws_tap_mask(TA, TB, TC, TD);
    localparam logic [W-1:0]          TAP_MASK  = FULL_MASK[W-1:0];
    localparam logic [W-1:0]          LOAD_VAL  = SEED[W-1:0];

    typedef struct packed {
        logic [W-1:0] sr;
    } lfsr_t;

    lfsr_t st_d, st_q;
    logic  fb;

    always_comb begin
        st_d = st_q;
        fb   = (^(st_q.sr & TAP_MASK)) ^ raw_bit;
        if (shift_en) begin
            st_d.sr = {st_q.sr[W-2:0], fb};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sr <= LOAD_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign state     = st_q.sr;
    assign white_bit = st_q.sr[W-1];

endmodule

// File: rtl/kws_packer.sv
module kws_packer #(
    parameter int unsigned KEY_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             bit_en,
    input  logic             bit_in,
    output logic             key_ready,
    output logic [KEY_W-1:0] key_word
);

    localparam int unsigned IW = $clog2(KEY_W);
    localparam logic [IW-1:0] LAST_IDX = IW'(KEY_W - 1);

    typedef struct packed {
        logic [KEY_W-1:0] word;
        logic [IW-1:0]    idx;
    } pack_t;

    pack_t pk_d, pk_q;

    always_comb begin
        pk_d      = pk_q;
        key_ready = 1'b0;
        if (clear) begin
            pk_d.idx = '0;
        end else if (bit_en) begin
            pk_d.word[pk_q.idx] = bit_in;
            if (pk_q.idx == LAST_IDX) begin
                key_ready = 1'b1;
                pk_d.idx  = '0;
            end else begin
                pk_d.idx = pk_q.idx + 1'b1;
            end
        end
        key_word = pk_d.word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pk_q <= '0;
        end else begin
            pk_q <= pk_d;
        end
    end

endmodule

// File: rtl/kws_ctrl.sv
module kws_ctrl #(
    parameter int unsigned DEPTH = 1024
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic                         key_ready,
    output logic [$clog2(DEPTH)-1:0]     wr_addr,
    output logic                         wr_en,
    output logic [$clog2(DEPTH+1)-1:0]   key_count,
    output logic                         done
);

    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(DEPTH - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          full;
    } ctrl_t;

    ctrl_t ct_d, ct_q;

    always_comb begin
        ct_d  = ct_q;
        wr_en = 1'b0;
        if (start) begin
            ct_d.cnt  = '0;
            ct_d.full = 1'b0;
        end else if (key_ready && !ct_q.full) begin
            wr_en    = 1'b1;
            ct_d.cnt = ct_q.cnt + 1'b1;
            if (ct_q.cnt == LAST_CNT) begin
                ct_d.full = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ct_q <= '0;
        end else begin
            ct_q <= ct_d;
        end
    end

    assign wr_addr   = ct_q.cnt[AW-1:0];
    assign key_count = ct_q.cnt;
    assign done      = ct_q.full;

endmodule

// File: rtl/kws_key_ram.sv
module kws_key_ram #(
    parameter int unsigned KEY_W = 128,
    parameter int unsigned DEPTH = 1024
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [KEY_W-1:0]         wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [KEY_W-1:0]         rdata
);

    logic [KEY_W-1:0] mem [DEPTH];

    // Read-first: a same-address read sees the entry before this write
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/key_whitener_store.sv
module key_whitener_store
    import kws_pkg::*;
#(
    parameter int unsigned           LFSR_W = KWS_LFSR_W,
    parameter int unsigned           KEY_W  = KWS_KEY_W,
    parameter int unsigned           DEPTH  = KWS_DEPTH,
    parameter logic [KWS_LFSR_W-1:0] SEED   = KWS_SEED,
    localparam int unsigned          AW     = $clog2(DEPTH),
    localparam int unsigned          CW     = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raw_bit,
    input  logic             raw_valid,
    input  logic             start,
    input  logic [AW-1:0]    rd_addr,
    output logic             done,
    output logic [CW-1:0]    key_count,
    output logic [KEY_W-1:0] rd_data
);

    logic [LFSR_W-1:0] lfsr_state;
    logic              white_bit;
    logic              accept;
    logic              key_ready;
    logic [KEY_W-1:0]  key_word;
    logic [AW-1:0]     wr_addr;
    logic              wr_en;

    // A raw bit is taken only while collecting and not restarting
    assign accept = raw_valid && !done && !start;

    kws_lfsr #(
        .W    (LFSR_W),
        .SEED (SEED),
        .TA   (KWS_TAP_A),
        .TB   (KWS_TAP_B),
        .TC   (KWS_TAP_C),
        .TD   (KWS_TAP_D)
    ) u_lfsr (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (accept),
        .raw_bit   (raw_bit),
        .state     (lfsr_state),
        .white_bit (white_bit)
    );

    kws_packer #(
        .KEY_W (KEY_W)
    ) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start),
        .bit_en    (accept),
        .bit_in    (white_bit),
        .key_ready (key_ready),
        .key_word  (key_word)
    );

    kws_ctrl #(
        .DEPTH (DEPTH)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .key_ready (key_ready),
        .wr_addr   (wr_addr),
        .wr_en     (wr_en),
        .key_count (key_count),
        .done      (done)
    );

    kws_key_ram #(
        .KEY_W (KEY_W),
        .DEPTH (DEPTH)
    ) u_ram (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (key_word),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

endmodule

// File: rtl/kws_checker.sv
module kws_checker #(
    parameter int unsigned LFSR_W = 128,
    parameter int unsigned DEPTH  = 1024,
    localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              raw_valid,
    input logic              done,
    input logic [CW-1:0]     key_count,
    input logic [LFSR_W-1:0] lfsr_state
);

    // R6: count never exceeds the store depth
    p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        key_count <= CW'(DEPTH));

    // R6: completion flag and full count agree
    p_done_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done == (key_count == CW'(DEPTH)));

    // R5: without start the count holds or steps by one
    p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (key_count == $past(key_count)) ||
                   (key_count == $past(key_count) + 1'b1));

    // R7: start clears the run
    p_start_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (key_count == '0) && !done);

    // R6: a finished run holds until start
    p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done && $stable(key_count));

    // R3: no accepted bit, no whitener movement
    p_idle_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!raw_valid || done || start) |=> $stable(lfsr_state));

    // R2: an accepted bit moves every stage up by one
    p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_valid && !done && !start) |=>
            lfsr_state[LFSR_W-1:1] == $past(lfsr_state[LFSR_W-2:0]));

endmodule

bind key_whitener_store kws_checker #(
    .LFSR_W (LFSR_W),
    .DEPTH  (DEPTH)
) u_kws_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .raw_valid  (raw_valid),
    .done       (done),
    .key_count  (key_count),
    .lfsr_state (lfsr_state)
);

// File: tb/key_whitener_store_bench.sv
`timescale 1ns/1ps
module key_whitener_store_bench;

    localparam int unsigned   DEPTH = 1024;
    localparam int unsigned   KW    = 128;
    localparam int unsigned   AW    = 10;
    localparam int unsigned   CW    = 11;
    localparam logic [127:0]  SEED_V = 128'h0123_4567_89AB_CDEF_F00D_CAFE_1357_9BDF;
    localparam int            WATCHDOG = 190000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          raw_bit = 1'b0;
    logic          raw_valid = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          done;
    logic [CW-1:0] key_count;
    logic [KW-1:0] rd_data;

    always #10 clk = ~clk;

    key_whitener_store #(
        .SEED (SEED_V)
    ) u_key_whitener_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .raw_bit   (raw_bit),
        .raw_valid (raw_valid),
        .start     (start),
        .rd_addr   (rd_addr),
        .done      (done),
        .key_count (key_count),
        .rd_data   (rd_data)
    );

    // Reference model state (behavioural)
    logic [127:0] m_reg;
    bit           m_bits[$];
    int           m_cnt;
    bit           m_done;
    logic [127:0] m_mem [DEPTH];
    bit           m_have [DEPTH];
    logic [127:0] m_rd;
    bit           m_rd_ok;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 0;
    logic [31:0] rng = 32'h1D2C_3B4A;

    function automatic bit next_rand();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return rng[0];
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    // Model one clock with the given inputs
    task automatic model_step(input bit v, input bit b, input bit s, input int ra);
        bit w, fb;
        logic [127:0] key;
        m_rd_ok = m_have[ra];
        m_rd    = m_mem[ra];
        if (s) begin
            m_cnt  = 0;
            m_done = 0;
            m_bits.delete();
        end else if (v && !m_done) begin
            w  = m_reg[127];
            fb = m_reg[127] ^ m_reg[125] ^ m_reg[100] ^ m_reg[98] ^ b;
            m_reg = {m_reg[126:0], fb};
            m_bits.push_back(w);
            if (m_bits.size() == 128) begin
                for (int k = 0; k < 128; k++) key[k] = m_bits[k];
                m_bits.delete();
                m_mem[m_cnt]  = key;
                m_have[m_cnt] = 1;
                m_cnt++;
                if (m_cnt == DEPTH) m_done = 1;
            end
        end
    endtask

    // Drive one cycle from a falling edge, compare at the next falling edge
    task automatic cyc(input bit v, input bit b, input bit s, input int ra, input string tag);
        raw_valid = v;
        raw_bit   = b;
        start     = s;
        rd_addr   = ra[AW-1:0];
        @(posedge clk);
        model_step(v, b, s, ra);
        @(negedge clk);
        chk(key_count == CW'(m_cnt), tag, "key_count (R5)", 128'(key_count), 128'(m_cnt));
        chk(done == m_done, tag, "done (R6)", 128'(done), 128'(m_done));
        if (m_rd_ok)
            chk(rd_data === m_rd, tag, "rd_data (R8)", rd_data, m_rd);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int ra;
        m_reg  = SEED_V;
        m_cnt  = 0;
        m_done = 0;
        for (int i = 0; i < DEPTH; i++) m_have[i] = 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(key_count == '0, "R1", "key_count after reset", 128'(key_count), 128'd0);
        chk(done == 1'b0, "R1", "done after reset", 128'(done), 128'd0);

        // R3: gapped stream; every third cycle has no valid bit
        for (int i = 0; i < 600; i++)
            cyc((i % 3) != 2, next_rand(), 1'b0, 0, "R3");

        // R4 R5: continuous stream until full, reading the latest key
        while (!m_done) begin
            ra = (m_cnt == 0) ? 0 : m_cnt - 1;
            cyc(1'b1, next_rand(), 1'b0, ra, "R4");
        end

        // R6: bits offered after full are ignored
        for (int i = 0; i < 80; i++)
            cyc(1'b1, next_rand(), 1'b0, i, "R6");

        // R2 R4 R8: read back every stored key
        for (int i = 0; i < DEPTH; i++)
            cyc(1'b0, 1'b0, 1'b0, i, "R2 R4 R8");
        cyc(1'b0, 1'b0, 1'b0, 0, "R8");

        // R7: start with a valid bit in the same cycle; bit dropped
        cyc(1'b1, 1'b1, 1'b1, 0, "R7");
        chk(key_count == '0 && !done, "R7", "cleared after start",
            128'({done, key_count}), 128'd0);

        // R7: partial key then another start discards it
        for (int i = 0; i < 64; i++)
            cyc(1'b1, next_rand(), 1'b0, 0, "R7");
        cyc(1'b0, 1'b0, 1'b1, 0, "R7");

        // R9: overwrite entry 0 while reading it
        for (int i = 0; i < 128; i++)
            cyc(1'b1, next_rand(), 1'b0, 0, "R9");
        cyc(1'b0, 1'b0, 1'b0, 0, "R9");
        chk(key_count == CW'(1), "R9", "one key in new run", 128'(key_count), 128'd1);

        for (int i = 0; i < 128; i++)
            cyc(1'b1, next_rand(), 1'b0, 1, "R5");
        cyc(1'b0, 1'b0, 1'b0, 1, "R8");
        cyc(1'b0, 1'b0, 1'b0, 0, "R8");

        finished = 1;
        summary();
        $finish;
    end

endmodule